// File: doc/BRIEF.md
# Paired-Word Load Sequencer

This block carries out a load of two word-sized registers from two adjacent memory words. A request names a byte address, two destination register indices, a base register index, a writeback enable with a signed offset, and a data endianness flag. The sequencer picks the access shape from the address alignment. A doubleword-aligned address gets one wide access that is atomic as a whole. A word-aligned address that is not doubleword-aligned gets two word accesses, each atomic on its own. Any other address raises an alignment fault without touching memory.

Nothing reaches the register file until every memory access of the request has returned without a fault. The sequencer then writes the first destination, the second destination and, when enabled, the updated base, one write per cycle. A fault on either access, including the second one of a pair, leaves every register untouched. This holds even when a destination is also the base. In that case the fault reports the address that failed.

The block sits between instruction decode and a single-outstanding memory port. It gives the pipeline a completion pulse or a fault pulse for each request.

Top module: `pair_load_seq`

## Requirements
- R1: An address whose low three bits are zero produces exactly one memory access, with `mem_wide`=1 and `mem_addr` equal to the request address.
- R2: An address whose low two bits are zero and whose bit 2 is one produces exactly two accesses with `mem_wide`=0: the first at the request address, the second at the request address plus 4.
- R3: An address whose low two bits are not both zero produces no memory access and no register write. It produces a one-cycle `fault` pulse with `fault_align`=1 and `fault_addr` equal to the request address.
- R4: For a word access the data is taken from `mem_rdata[31:0]`. The word from the lower address goes to the first destination and the word from the higher address goes to the second destination.
- R5: For a wide access with `req_big_endian`=0, the first destination receives `mem_rdata[31:0]` and the second receives `mem_rdata[63:32]`. With `req_big_endian`=1, the first destination receives `mem_rdata[63:32]` and the second receives `mem_rdata[31:0]`.
- R6: An acknowledge with `mem_fault`=1 on any access ends the request with a one-cycle `fault` pulse. `fault_align` is 0 and `fault_addr` is the address of the faulting access. No register write is issued for that request, including when a destination equals the base.
- R7: The first register write occurs in the cycle after the final successful acknowledge. Writes follow in this order: first destination, second destination, then the base when written, in consecutive cycles. `done` pulses for one cycle in the cycle after the last write.
- R8: With `req_wb`=1 and no overlap, the base register is written with the request address plus `req_offset` (modulo 2^32). The +4 step of the second access is not applied.
- R9: With `req_wb`=1 and the base index equal to either destination index, both destinations are still written and the base write is dropped. `wb_conflict` is 1 in the `done` cycle and 0 otherwise.
- R10: `mem_req` stays high with `mem_addr` and `mem_wide` stable until `mem_ack`. At most one access is outstanding. `req_ready` is 1 only while idle, and no access or write happens while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_addr | input | 32 | Byte address of the lower word |
| req_rd1 | input | 4 | First destination register index |
| req_rd2 | input | 4 | Second destination register index |
| req_base | input | 4 | Base register index |
| req_wb | input | 1 | Write the updated base |
| req_offset | input | 32 | Offset added to the address for the base update |
| req_big_endian | input | 1 | Data endianness, 1 = big-endian |
| mem_req | output | 1 | Memory access request |
| mem_addr | output | 32 | Access address |
| mem_wide | output | 1 | 1 = 64-bit access, 0 = 32-bit access |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 64 | Returned data, word accesses in the low half |
| mem_fault | input | 1 | Access faulted, valid with `mem_ack` |
| rf_we | output | 1 | Register file write enable |
| rf_idx | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| done | output | 1 | Request completed |
| fault | output | 1 | Request ended in a fault |
| fault_align | output | 1 | Fault was an alignment fault |
| fault_addr | output | 32 | Address that caused the fault |
| wb_conflict | output | 1 | Writeback dropped because of overlap, with `done` |

## Verification
The bench targets a fault on the second word of a pair where the first destination is also the base. A design that commits early would show a write of the first destination before the fault. It also loads the same doubleword under both endiannesses. Swapped lanes would put the higher-address word into the first destination. Word-aligned pairs carry a base update, so a design that kept the +4 correction would write the base with an address 4 too high or too low. Misaligned addresses, a fault on the first access, overlapping writeback and zero-latency acknowledges are also covered. They catch a stray memory request, a wrong fault address, a base write that should have been dropped, and an off-by-one in the commit timing.

// File: rtl/pls_pkg.sv
package pls_pkg;
   typedef enum logic [1:0] {
      ALN_WIDE = 2'd0,
      ALN_PAIR = 2'd1,
      ALN_BAD  = 2'd2
   } aln_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ACC1 = 3'd1,
      ST_ACC2 = 3'd2,
      ST_WR1  = 3'd3,
      ST_WR2  = 3'd4,
      ST_WRB  = 3'd5,
      ST_DONE = 3'd6,
      ST_FLT  = 3'd7
   } st_e;
endpackage

// File: rtl/pls_align_dec.sv
module pls_align_dec
   import pls_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WORD_BYTES  = 4,
   parameter bit ATOMIC_WIDE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output aln_e              kind
);
   localparam logic [ADDR_W-1:0] WORD_MASK  = ADDR_W'(WORD_BYTES - 1);
   localparam logic [ADDR_W-1:0] DWORD_MASK = ADDR_W'(2 * WORD_BYTES - 1);

   logic word_ok;
   logic dword_ok;

   assign word_ok  = (addr & WORD_MASK) == '0;
   assign dword_ok = (addr & DWORD_MASK) == '0;

   generate
      if (ATOMIC_WIDE) begin : g_wide
         always_comb begin
            if (!word_ok)      kind = ALN_BAD;
            else if (dword_ok) kind = ALN_WIDE;
            else               kind = ALN_PAIR;
         end
      end else begin : g_pair_only
         always_comb begin
            if (!word_ok) kind = ALN_BAD;
            else          kind = ALN_PAIR;
         end
      end
   endgenerate
endmodule

// File: rtl/pls_lane_steer.sv
module pls_lane_steer #(
   parameter int WORD_W = 32
) (
   input  logic [2*WORD_W-1:0] dword,
   input  logic                big_endian,
   output logic [WORD_W-1:0]   lo_word,
   output logic [WORD_W-1:0]   hi_word
);
   logic [WORD_W-1:0] lane0;
   logic [WORD_W-1:0] lane1;

   assign lane0 = dword[WORD_W-1:0];
   assign lane1 = dword[2*WORD_W-1:WORD_W];

   always_comb begin
      if (big_endian) begin
         lo_word = lane1;
         hi_word = lane0;
      end else begin
         lo_word = lane0;
         hi_word = lane1;
      end
   end
endmodule

// File: rtl/pls_wb_calc.sv
module pls_wb_calc #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] offset,
   input  logic              wb,
   input  logic [IDX_W-1:0]  rd1,
   input  logic [IDX_W-1:0]  rd2,
   input  logic [IDX_W-1:0]  base,
   output logic [ADDR_W-1:0] new_base,
   output logic              do_wb,
   output logic              conflict
);
   logic overlap;

   assign overlap  = (base == rd1) || (base == rd2);
   assign new_base = addr + offset;
   assign do_wb    = wb && !overlap;
   assign conflict = wb && overlap;
endmodule

// File: rtl/pair_load_seq.sv
module pair_load_seq
   import pls_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WORD_W      = 32,
   parameter int IDX_W       = 4,
   parameter bit ATOMIC_WIDE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [IDX_W-1:0]    req_rd1,
   input  logic [IDX_W-1:0]    req_rd2,
   input  logic [IDX_W-1:0]    req_base,
   input  logic                req_wb,
   input  logic [ADDR_W-1:0]   req_offset,
   input  logic                req_big_endian,
   output logic                mem_req,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_wide,
   input  logic                mem_ack,
   input  logic [2*WORD_W-1:0] mem_rdata,
   input  logic                mem_fault,
   output logic                rf_we,
   output logic [IDX_W-1:0]    rf_idx,
   output logic [WORD_W-1:0]   rf_wdata,
   output logic                done,
   output logic                fault,
   output logic                fault_align,
   output logic [ADDR_W-1:0]   fault_addr,
   output logic                wb_conflict
);
   localparam int WORD_BYTES = WORD_W / 8;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   generate
      if (WORD_W < 16 || (WORD_W % 8) != 0 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("pair_load_seq: WORD_W must be a power-of-two byte multiple of at least 16");
      end
      if (ADDR_W != WORD_W) begin : g_bad_addr
         $error("pair_load_seq: ADDR_W must equal WORD_W so the base can be written back");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("pair_load_seq: IDX_W must be at least 1");
      end
   endgenerate

   st_e               state_q;
   aln_e              kind_d;
   aln_e              kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [IDX_W-1:0]  rd1_q;
   logic [IDX_W-1:0]  rd2_q;
   logic [IDX_W-1:0]  base_q;
   logic              be_q;
   logic [ADDR_W-1:0] nbase_d;
   logic [ADDR_W-1:0] nbase_q;
   logic              dowb_d;
   logic              dowb_q;
   logic              conf_d;
   logic              conf_q;
   logic [WORD_W-1:0] lo_q;
   logic [WORD_W-1:0] hi_q;
   logic [WORD_W-1:0] steer_lo;
   logic [WORD_W-1:0] steer_hi;
   logic              align_q;
   logic [ADDR_W-1:0] faddr_q;
   logic              accept;

   pls_align_dec #(
      .ADDR_W     (ADDR_W),
      .WORD_BYTES (WORD_BYTES),
      .ATOMIC_WIDE(ATOMIC_WIDE)
   ) u_align (
      .addr(req_addr),
      .kind(kind_d)
   );

   pls_wb_calc #(
      .ADDR_W(ADDR_W),
      .IDX_W (IDX_W)
   ) u_wb (
      .addr    (req_addr),
      .offset  (req_offset),
      .wb      (req_wb),
      .rd1     (req_rd1),
      .rd2     (req_rd2),
      .base    (req_base),
      .new_base(nbase_d),
      .do_wb   (dowb_d),
      .conflict(conf_d)
   );

   pls_lane_steer #(
      .WORD_W(WORD_W)
   ) u_steer (
      .dword     (mem_rdata),
      .big_endian(be_q),
      .lo_word   (steer_lo),
      .hi_word   (steer_hi)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= ALN_PAIR;
         addr_q  <= '0;
         rd1_q   <= '0;
         rd2_q   <= '0;
         base_q  <= '0;
         be_q    <= 1'b0;
         nbase_q <= '0;
         dowb_q  <= 1'b0;
         conf_q  <= 1'b0;
         lo_q    <= '0;
         hi_q    <= '0;
         align_q <= 1'b0;
         faddr_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  kind_q  <= kind_d;
                  addr_q  <= req_addr;
                  rd1_q   <= req_rd1;
                  rd2_q   <= req_rd2;
                  base_q  <= req_base;
                  be_q    <= req_big_endian;
                  nbase_q <= nbase_d;
                  dowb_q  <= dowb_d;
                  conf_q  <= conf_d;
                  if (kind_d == ALN_BAD) begin
                     align_q <= 1'b1;
                     faddr_q <= req_addr;
                     state_q <= ST_FLT;
                  end else begin
                     state_q <= ST_ACC1;
                  end
               end
            end
            ST_ACC1: begin
               if (mem_ack) begin
                  if (mem_fault) begin
                     align_q <= 1'b0;
                     faddr_q <= mem_addr;
                     state_q <= ST_FLT;
                  end else if (kind_q == ALN_WIDE) begin
                     lo_q    <= steer_lo;
                     hi_q    <= steer_hi;
                     state_q <= ST_WR1;
                  end else begin
                     lo_q    <= mem_rdata[WORD_W-1:0];
                     state_q <= ST_ACC2;
                  end
               end
            end
            ST_ACC2: begin
               if (mem_ack) begin
                  if (mem_fault) begin
                     align_q <= 1'b0;
                     faddr_q <= mem_addr;
                     state_q <= ST_FLT;
                  end else begin
                     hi_q    <= mem_rdata[WORD_W-1:0];
                     state_q <= ST_WR1;
                  end
               end
            end
            ST_WR1:  state_q <= ST_WR2;
            ST_WR2:  state_q <= dowb_q ? ST_WRB : ST_DONE;
            ST_WRB:  state_q <= ST_DONE;
            ST_DONE: state_q <= ST_IDLE;
            ST_FLT:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = (state_q == ST_ACC1) || (state_q == ST_ACC2);
      mem_wide = (state_q == ST_ACC1) && (kind_q == ALN_WIDE);
      mem_addr = (state_q == ST_ACC2) ? addr_q + STEP : addr_q;
   end

   always_comb begin
      rf_we    = 1'b0;
      rf_idx   = '0;
      rf_wdata = '0;
      case (state_q)
         ST_WR1: begin
            rf_we    = 1'b1;
            rf_idx   = rd1_q;
            rf_wdata = lo_q;
         end
         ST_WR2: begin
            rf_we    = 1'b1;
            rf_idx   = rd2_q;
            rf_wdata = hi_q;
         end
         ST_WRB: begin
            rf_we    = 1'b1;
            rf_idx   = base_q;
            rf_wdata = WORD_W'(nbase_q);
         end
         default: ;
      endcase
   end

   assign done        = (state_q == ST_DONE);
   assign fault       = (state_q == ST_FLT);
   assign fault_align = fault && align_q;
   assign fault_addr  = faddr_q;
   assign wb_conflict = done && conf_q;
endmodule

// File: rtl/pls_checker.sv
module pls_checker #(
   parameter int ADDR_W      = 32,
   parameter int WORD_W      = 32,
   parameter int IDX_W       = 4,
   parameter bit ATOMIC_WIDE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_wide,
   input logic              mem_ack,
   input logic              mem_fault,
   input logic              rf_we,
   input logic              done,
   input logic              fault,
   input logic              fault_align,
   input logic              wb_conflict
);
   localparam logic [ADDR_W-1:0] WMASK = ADDR_W'(WORD_W / 8 - 1);
   localparam logic [ADDR_W-1:0] DMASK = ADDR_W'(WORD_W / 4 - 1);

   logic take;
   logic a_bad;
   logic a_dw;

   assign take  = req_valid && req_ready;
   assign a_bad = (req_addr & WMASK) != '0;
   assign a_dw  = (req_addr & DMASK) == '0;

   generate
      if (ATOMIC_WIDE) begin : g_wide_chk
         AST_WIDE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            take && a_dw |=> mem_req && mem_wide && mem_addr == $past(req_addr)); // R1
         AST_PAIR_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
            take && !a_bad && !a_dw |=> mem_req && !mem_wide && mem_addr == $past(req_addr)); // R2
      end
   endgenerate

   AST_BAD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      take && a_bad |=> fault && fault_align && !mem_req && !rf_we); // R3
   AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && mem_fault |=> fault && !fault_align && !rf_we); // R6
   AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !rf_we && !done); // R6
   AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rf_we) && !rf_we); // R7
   AST_CONFLICT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_conflict |-> done); // R9
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wide)); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req && !rf_we); // R10
endmodule

bind pair_load_seq pls_checker #(
   .ADDR_W     (ADDR_W),
   .WORD_W     (WORD_W),
   .IDX_W      (IDX_W),
   .ATOMIC_WIDE(ATOMIC_WIDE)
) u_pls_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_addr   (req_addr),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_wide   (mem_wide),
   .mem_ack    (mem_ack),
   .mem_fault  (mem_fault),
   .rf_we      (rf_we),
   .done       (done),
   .fault      (fault),
   .fault_align(fault_align),
   .wb_conflict(wb_conflict)
);

// File: tb/pair_load_seq_bench.sv
`timescale 1ns/1ps
module pair_load_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_rd1 = '0;
   logic [3:0]  req_rd2 = '0;
   logic [3:0]  req_base = '0;
   logic        req_wb = 1'b0;
   logic [31:0] req_offset = '0;
   logic        req_big_endian = 1'b0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_wide;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        mem_fault = 1'b0;
   logic        rf_we;
   logic [3:0]  rf_idx;
   logic [31:0] rf_wdata;
   logic        done;
   logic        fault;
   logic        fault_align;
   logic [31:0] fault_addr;
   logic        wb_conflict;

   always #4 clk = ~clk;

   pair_load_seq u_pair_load_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_rd1(req_rd1), .req_rd2(req_rd2), .req_base(req_base),
      .req_wb(req_wb), .req_offset(req_offset), .req_big_endian(req_big_endian),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_wide(mem_wide),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_fault(mem_fault),
      .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
      .done(done), .fault(fault), .fault_align(fault_align),
      .fault_addr(fault_addr), .wb_conflict(wb_conflict)
   );

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   logic [31:0] fault_at = 32'hFFFF_FFFF;
   int          lat = 0;
   int          lat_cnt = 0;

   function automatic logic [31:0] mw(input logic [31:0] a);
      return a ^ 32'hC0DE_5A5A;
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // memory responder: one access at a time, configurable latency
   always @(posedge clk) begin
      if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (lat_cnt >= lat) begin
            mem_ack   <= 1'b1;
            mem_fault <= (mem_addr == fault_at);
            if (mem_wide)
               mem_rdata <= req_big_endian ? {mw(mem_addr), mw(mem_addr + 32'd4)}
                                           : {mw(mem_addr + 32'd4), mw(mem_addr)};
            else
               mem_rdata <= {32'hDEAD_BEEF, mw(mem_addr)};
            lat_cnt <= 0;
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   // logs, sampled mid-cycle
   int          wr_n = 0;
   logic [3:0]  wr_idx [16];
   logic [31:0] wr_dat [16];
   int          wr_cyc [16];
   int          acc_n = 0;
   logic [31:0] acc_addr [16];
   logic        acc_wide [16];
   int          ack_cyc = 0;

   always @(negedge clk) begin
      if (rf_we) begin
         wr_idx[wr_n % 16] = rf_idx;
         wr_dat[wr_n % 16] = rf_wdata;
         wr_cyc[wr_n % 16] = cyc;
         wr_n = wr_n + 1;
      end
      if (mem_ack && mem_req) begin
         acc_addr[acc_n % 16] = mem_addr;
         acc_wide[acc_n % 16] = mem_wide;
         ack_cyc = cyc;
         acc_n = acc_n + 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // vector: addr, offset, fault_at, rd1, rd2, base, wb, be, lat
   localparam int VW = 32 * 3 + 4 * 3 + 2 + 4;
   localparam int NV = 10;
   localparam logic [VW-1:0] TBL [NV] = '{
      {32'h0000_1000, 32'h0000_0000, 32'hFFFF_FFFF, 4'd1, 4'd2, 4'd9, 1'b0, 1'b0, 4'd1},
      {32'h0000_1000, 32'h0000_0000, 32'hFFFF_FFFF, 4'd1, 4'd2, 4'd9, 1'b0, 1'b1, 4'd0},
      {32'h0000_2004, 32'h0000_0008, 32'hFFFF_FFFF, 4'd1, 4'd2, 4'd5, 1'b1, 1'b0, 4'd2},
      {32'h0000_2104, 32'hFFFF_FFF8, 32'hFFFF_FFFF, 4'd6, 4'd7, 4'd8, 1'b1, 1'b1, 4'd0},
      {32'h0000_3008, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 4'd3, 4'd4, 4'd11, 1'b1, 1'b1, 4'd3},
      {32'h0000_4004, 32'h0000_0008, 32'h0000_4008, 4'd2, 4'd3, 4'd2, 1'b0, 1'b0, 4'd1},
      {32'h0000_5000, 32'h0000_0000, 32'h0000_5000, 4'd2, 4'd3, 4'd4, 1'b1, 1'b0, 4'd2},
      {32'h0000_6002, 32'h0000_0004, 32'hFFFF_FFFF, 4'd2, 4'd3, 4'd4, 1'b1, 1'b0, 4'd0},
      {32'h0000_7004, 32'h0000_0004, 32'h0000_7004, 4'd2, 4'd3, 4'd2, 1'b1, 1'b0, 4'd1},
      {32'h0000_8000, 32'h0000_0010, 32'hFFFF_FFFF, 4'd4, 4'd5, 4'd5, 1'b1, 1'b0, 4'd0}
   };

   task automatic run_vec(input logic [VW-1:0] v, input int n);
      logic [31:0] a, off, fa;
      logic [3:0]  r1, r2, b;
      logic        wb, be;
      bit          mis, wide, exp_flt, overlap;
      logic [31:0] exp_faddr;
      int          exp_acc, exp_wr, w0, a0, waited, end_cyc;
      bit          got_done, got_flt, got_align, got_conf;
      logic [31:0] got_faddr;
      string       tg;
      {a, off, fa, r1, r2, b, wb, be} = v[VW-1:4];
      tg = $sformatf("vec%0d", n);
      mis = a[1:0] != 2'b00;
      wide = a[2] == 1'b0;
      overlap = (b == r1) || (b == r2);
      exp_flt = 1'b0;
      exp_faddr = '0;
      if (mis) begin
         exp_acc = 0; exp_flt = 1'b1; exp_faddr = a;
      end else if (wide) begin
         exp_acc = 1;
         if (fa == a) begin exp_flt = 1'b1; exp_faddr = a; end
      end else begin
         if (fa == a) begin exp_acc = 1; exp_flt = 1'b1; exp_faddr = a; end
         else begin
            exp_acc = 2;
            if (fa == a + 32'd4) begin exp_flt = 1'b1; exp_faddr = a + 32'd4; end
         end
      end
      exp_wr = exp_flt ? 0 : ((wb && !overlap) ? 3 : 2);

      @(negedge clk);
      fault_at = fa;
      lat = int'(v[3:0]);
      req_addr = a; req_offset = off; req_rd1 = r1; req_rd2 = r2;
      req_base = b; req_wb = wb; req_big_endian = be;
      w0 = wr_n; a0 = acc_n;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready == 1'b0, "R10", {tg, " busy ready"}, 64'(req_ready), 64'd0);
      got_done = 0; got_flt = 0; got_align = 0; got_conf = 0; got_faddr = '0;
      end_cyc = 0; waited = 0;
      while (!got_done && !got_flt && waited < 100) begin
         if (done) begin got_done = 1; got_conf = wb_conflict; end_cyc = cyc; end
         if (fault) begin got_flt = 1; got_align = fault_align; got_faddr = fault_addr; end
         if (!got_done && !got_flt) begin @(negedge clk); waited++; end
      end
      check(got_done || got_flt, "R7", {tg, " finished"}, 64'(waited), 64'd0);
      check(got_flt == exp_flt, exp_flt ? "R6" : "R7", {tg, " fault outcome"},
            64'(got_flt), 64'(exp_flt));
      check(acc_n - a0 == exp_acc, mis ? "R3" : (wide ? "R1" : "R2"),
            {tg, " access count"}, 64'(acc_n - a0), 64'(exp_acc));
      check(wr_n - w0 == exp_wr, exp_flt ? "R6" : "R7", {tg, " write count"},
            64'(wr_n - w0), 64'(exp_wr));
      if (!mis && acc_n - a0 >= 1) begin
         check(acc_addr[a0 % 16] == a && acc_wide[a0 % 16] == wide,
               wide ? "R1" : "R2", {tg, " first access"},
               {31'd0, acc_wide[a0 % 16], acc_addr[a0 % 16]}, {31'd0, wide, a});
      end
      if (exp_acc == 2 && acc_n - a0 == 2) begin
         check(acc_addr[(a0 + 1) % 16] == a + 32'd4 && !acc_wide[(a0 + 1) % 16], "R2",
               {tg, " second access"}, 64'(acc_addr[(a0 + 1) % 16]), 64'(a + 32'd4));
      end
      if (exp_flt) begin
         check(got_faddr == exp_faddr, mis ? "R3" : "R6", {tg, " fault addr"},
               64'(got_faddr), 64'(exp_faddr));
         check(got_align == mis, mis ? "R3" : "R6", {tg, " align flag"},
               64'(got_align), 64'(mis));
      end else if (wr_n - w0 == exp_wr) begin
         check(wr_idx[w0 % 16] == r1 && wr_dat[w0 % 16] == mw(a), wide ? "R5" : "R4",
               {tg, " first dest"}, {28'd0, wr_idx[w0 % 16], wr_dat[w0 % 16]},
               {28'd0, r1, mw(a)});
         check(wr_idx[(w0 + 1) % 16] == r2 && wr_dat[(w0 + 1) % 16] == mw(a + 32'd4),
               wide ? "R5" : "R4", {tg, " second dest"},
               {28'd0, wr_idx[(w0 + 1) % 16], wr_dat[(w0 + 1) % 16]},
               {28'd0, r2, mw(a + 32'd4)});
         check(wr_cyc[w0 % 16] == ack_cyc + 1, "R7", {tg, " first write timing"},
               64'(wr_cyc[w0 % 16]), 64'(ack_cyc + 1));
         check(wr_cyc[(w0 + exp_wr - 1) % 16] == wr_cyc[w0 % 16] + exp_wr - 1 &&
               end_cyc == wr_cyc[(w0 + exp_wr - 1) % 16] + 1, "R7", {tg, " done timing"},
               64'(end_cyc), 64'(wr_cyc[w0 % 16] + exp_wr));
         if (exp_wr == 3) begin
            check(wr_idx[(w0 + 2) % 16] == b && wr_dat[(w0 + 2) % 16] == a + off, "R8",
                  {tg, " base update"}, {28'd0, wr_idx[(w0 + 2) % 16], wr_dat[(w0 + 2) % 16]},
                  {28'd0, b, a + off});
         end
         check(got_conf == (wb && overlap), "R9", {tg, " conflict flag"},
               64'(got_conf), 64'(wb && overlap));
      end
      @(negedge clk);
      check(req_ready && !rf_we && !mem_req, "R10", {tg, " back to idle"},
            {61'd0, req_ready, rf_we, mem_req}, 64'h4);
   endtask

   bit finished = 0;

   initial begin
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1 && !mem_req && !rf_we && !done && !fault && !wb_conflict,
            "R10", "reset state", {58'd0, req_ready, mem_req, rf_we, done, fault, wb_conflict},
            64'h20);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && !mem_req, "R10", "idle after reset",
            {62'd0, req_ready, mem_req}, 64'h2);
      for (int i = 0; i < NV; i++) run_vec(TBL[i], i);
      // directed: second-word fault where first destination is the base, with writeback
      run_vec({32'h0000_9FFC, 32'h0000_0004, 32'h0000_A000, 4'd2, 4'd3, 4'd2, 1'b1, 1'b1, 4'd0}, 100);
      // directed: misaligned by one and by three
      run_vec({32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFF, 4'd1, 4'd2, 4'd3, 1'b0, 1'b0, 4'd0}, 101);
      run_vec({32'h0000_0007, 32'h0000_0000, 32'hFFFF_FFFF, 4'd1, 4'd2, 4'd3, 1'b0, 1'b1, 4'd0}, 102);
      // directed: overlap of second destination with base, wide, big-endian
      run_vec({32'hFFFF_FFF8, 32'h0000_0010, 32'hFFFF_FFFF, 4'd7, 4'd8, 4'd8, 1'b1, 1'b1, 4'd1}, 103);
      // directed: pair with wrapping base update
      run_vec({32'hFFFF_FFF4, 32'h0000_0010, 32'hFFFF_FFFF, 4'd1, 4'd2, 4'd15, 1'b1, 1'b0, 4'd0}, 104);
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL R7 watchdog expired: actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule